// File: doc/BRIEF.md
# Octal Converter Command Register File

This block sits behind the serial framing logic of an eight-channel digital-to-analog converter. Each complete 16-bit command word arrives with a one-cycle `word_valid` strobe. The block splits the word into a 4-bit address and a 12-bit payload, and stores the payload in one of several places:

- eight 8-bit channel input registers;
- a global control register;
- a per-pair control register;
- a preset register.

Eight output latches drive the converter codes. Every clock cycle that the active-low load input is low, the latches take a copy of the input registers. An active-low preset input forces every channel code to the preset register at once, whatever the load input is doing.

Complementary pair addresses write an 8-bit code into the first channel of a pair and its bitwise complement into the second. The pair's outputs then move in opposite directions. An optional two's-complement input format converts signed codes to offset binary before they are stored.

Channels are numbered 0 (A) to 7 (H). Pairs are numbered 0 (A/B) to 3 (G/H). Channel i drives `ch_code[8*i+7:8*i]`.

Top module: `octal_dac_regfile`

## Requirements
- R1: A word is split into address = bits 15:12 and payload = bits 11:0. A code is payload bits 11:4 (word bits 11:4). Word bits 3:0 never affect any channel code.
- R2: Addresses 0 to 7 write the input register of channel 0 to channel 7, in that order.
- R3: Address 8 writes the global control fields: `chip_pdn` = payload bit 4, `cascade_en` = payload bit 3, `twos_fmt` = payload bit 0 (0 = straight binary, 1 = two's complement).
- R4: Address 9 writes the pair controls. `pair_pdn[k]` = payload bit 4+k and `pair_fast[k]` = payload bit k (1 = fast), for pair k = 0 (A/B) to 3 (G/H).
- R5: Address 10 writes the preset register with the code. A write to address 11 changes no control field, no register and no output.
- R6: Addresses 12 to 15 select pair k = address−12. The write stores the code in channel 2k and its bitwise complement in channel 2k+1. For example, code 0xFF gives 0xFF on channel 2k and 0x00 on channel 2k+1.
- R7: A clock edge with `load_n` low copies every input register into its output latch, so a written code appears on `ch_code` one cycle after its input register updates. While `load_n` is high and preset is inactive, `ch_code` holds its value.
- R8: While `preset_n` is low, every channel code equals the preset register, without waiting for a clock edge. The preset value is 0x00 if the preset register was never written.
- R9: With `twos_fmt` = 1, the most significant bit of each code is inverted before it is stored in a channel or the preset register. The inversion is applied before the complement of a pair write. The new format applies from the word after the control write.
- R10: A clock edge with `preset_n` low loads the preset value into the output latches, so after release the codes keep that value until the next load. Preset takes priority over load.
- R11: After reset, all input registers, latches, the preset register and all control fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Strobe: word_data holds a complete command |
| word_data | input | 16 | Command word: address and payload |
| load_n | input | 1 | Active-low latch load enable |
| preset_n | input | 1 | Active-low preset force |
| ch_code | output | 64 | Eight latched 8-bit channel codes, channel 0 in bits 7:0 |
| pair_pdn | output | 4 | Power-down per channel pair |
| pair_fast | output | 4 | Speed select per channel pair, 1 = fast |
| chip_pdn | output | 1 | Whole-device power-down |
| cascade_en | output | 1 | Enable for the cascade serial output |
| twos_fmt | output | 1 | Input format, 1 = two's complement |

## Verification
Directed words cover each address class: single channels at both ends of the map, a pair write of 0xFF, a pair write in two's-complement mode, and both control registers with asymmetric bit patterns so that a swapped field index shows up. The reserved address is written with all ones. The directed part also walks through load gating and the preset timing: preset asserted before the preset register has ever been written, a preset register write while preset is held, release with load held high, and a later load. These separate the preset-over-load priority and the release-hold behaviour from plain register writes. The random part then mixes arbitrary words, load and preset levels and format changes. A reference model checks each cycle, so ordering faults between latch capture, format conversion and the complement show up in combinations the directed cases do not reach.

// File: rtl/octdac_pkg.sv
// Package: shared constants, address map and code conversion for the
// octal converter register file. Assumes a 16-bit word, 4-bit address.
package octdac_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int CODE_W   = 8;
    localparam int CODE_LSB = PAY_W - CODE_W;
    localparam int NUM_CH   = 8;
    localparam int NUM_PAIR = NUM_CH / 2;

    // Address map; the order is decoded by behaviour, not just naming.
    localparam logic [ADDR_W-1:0] ADR_GLB_CTRL  = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_PAIR_CTRL = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_PRESET    = 4'd10;
    localparam logic [ADDR_W-1:0] ADR_RESERVED  = 4'd11;
    localparam logic [ADDR_W-1:0] ADR_PAIR_BASE = 4'd12;

    // Bit positions inside the global control payload.
    localparam int GLB_PDN_BIT = 4;
    localparam int GLB_CAS_BIT = 3;
    localparam int GLB_FMT_BIT = 0;

    // Convert a signed code to offset binary when the format flag is set.
    function automatic logic [CODE_W-1:0] to_offset(input logic [CODE_W-1:0] raw,
                                                    input logic twos);
        to_offset = twos ? {~raw[CODE_W-1], raw[CODE_W-2:0]} : raw;
    endfunction
endpackage

// File: rtl/octdac_cmd_decode.sv
// Module: combinational decoder from a committed command word to write
// enables and data for channels and control registers.
// Assumes word_valid is a single-cycle strobe per word.
module octdac_cmd_decode
    import octdac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CODE_W
) (
    input  logic                 word_valid,
    input  logic [WORD_W-1:0]    word_data,
    input  logic                 twos_fmt,
    output logic [N_CH-1:0]      ch_we,
    output logic [N_CH*C_W-1:0]  ch_wdata,
    output logic                 glb_we,
    output logic                 pair_we,
    output logic                 preset_we,
    output logic [PAY_W-1:0]     payload,
    output logic [C_W-1:0]       code
);
    logic [ADDR_W-1:0] addr;
    logic              is_pair;

    // Split the word and convert the code into offset binary if needed.
    always_comb begin
        addr    = word_data[WORD_W-1:PAY_W];
        payload = word_data[PAY_W-1:0];
        code    = to_offset(payload[PAY_W-1:CODE_LSB], twos_fmt);
        is_pair = (addr >= ADR_PAIR_BASE);
    end

    // Decode the control and preset register write strobes.
    always_comb begin
        glb_we    = word_valid && (addr == ADR_GLB_CTRL);
        pair_we   = word_valid && (addr == ADR_PAIR_CTRL);
        preset_we = word_valid && (addr == ADR_PRESET);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] SELF_ADR = ADDR_W'(i);
        localparam logic [ADDR_W-1:0] PAIR_ADR = ADR_PAIR_BASE + ADDR_W'(i / 2);
        localparam bit                IS_ODD   = (i % 2) == 1;
        // Per-channel write enable: own address or its pair address.
        always_comb begin
            ch_we[i] = word_valid && ((addr == SELF_ADR) || (addr == PAIR_ADR));
            ch_wdata[i*C_W +: C_W] = (is_pair && IS_ODD) ? ~code : code;
        end
    end
endmodule

// File: rtl/octdac_ctrl_regs.sv
// Module: global control, pair control and preset registers.
// Assumes one write strobe at most per cycle; synchronous active-low reset.
module octdac_ctrl_regs
    import octdac_pkg::*;
#(
    parameter int N_PAIR = NUM_PAIR,
    parameter int C_W    = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_we,
    input  logic              pair_we,
    input  logic              preset_we,
    input  logic [PAY_W-1:0]  payload,
    input  logic [C_W-1:0]    code,
    output logic              chip_pdn,
    output logic              cascade_en,
    output logic              twos_fmt,
    output logic [N_PAIR-1:0] pair_pdn,
    output logic [N_PAIR-1:0] pair_fast,
    output logic [C_W-1:0]    preset_val
);
    // Global control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_pdn   <= 1'b0;
            cascade_en <= 1'b0;
            twos_fmt   <= 1'b0;
        end else if (glb_we) begin
            chip_pdn   <= payload[GLB_PDN_BIT];
            cascade_en <= payload[GLB_CAS_BIT];
            twos_fmt   <= payload[GLB_FMT_BIT];
        end
    end

    // Per-pair power-down and speed fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_pdn  <= '0;
            pair_fast <= '0;
        end else if (pair_we) begin
            pair_pdn  <= payload[2*N_PAIR-1:N_PAIR];
            pair_fast <= payload[N_PAIR-1:0];
        end
    end

    // Preset code register.
    always_ff @(posedge clk) begin
        if (!rst_n)         preset_val <= '0;
        else if (preset_we) preset_val <= code;
    end
endmodule

// File: rtl/octdac_channel_bank.sv
// Module: channel input registers and output latches with load gating and
// preset force. Assumes preset_n is already synchronous to clk for the
// latch capture path; the output force path is combinational.
module octdac_channel_bank
    import octdac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CH-1:0]     ch_we,
    input  logic [N_CH*C_W-1:0] ch_wdata,
    input  logic                load_n,
    input  logic                preset_n,
    input  logic [C_W-1:0]      preset_val,
    output logic [N_CH*C_W-1:0] in_regs,
    output logic [N_CH*C_W-1:0] ch_code
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [C_W-1:0] in_q;
        logic [C_W-1:0] lat_q;

        // Input register written by the decoder.
        always_ff @(posedge clk) begin
            if (!rst_n)       in_q <= '0;
            else if (ch_we[i]) in_q <= ch_wdata[i*C_W +: C_W];
        end

        // Output latch: preset wins over load.
        always_ff @(posedge clk) begin
            if (!rst_n)        lat_q <= '0;
            else if (!preset_n) lat_q <= preset_val;
            else if (!load_n)   lat_q <= in_q;
        end

        // Drive the channel code, forced to preset while preset is low.
        always_comb begin
            in_regs[i*C_W +: C_W] = in_q;
            ch_code[i*C_W +: C_W] = preset_n ? lat_q : preset_val;
        end
    end
endmodule

// File: rtl/octal_dac_regfile.sv
// Module: top of the octal converter register file. Connects the decoder,
// the control registers and the channel bank. Assumes words come from a
// framing block already in the clk domain.
module octal_dac_regfile
    import octdac_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int C_W  = CODE_W,
    localparam int N_PAIR = N_CH / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [WORD_W-1:0]   word_data,
    input  logic                load_n,
    input  logic                preset_n,
    output logic [N_CH*C_W-1:0] ch_code,
    output logic [N_PAIR-1:0]   pair_pdn,
    output logic [N_PAIR-1:0]   pair_fast,
    output logic                chip_pdn,
    output logic                cascade_en,
    output logic                twos_fmt
);
    logic [N_CH-1:0]     ch_we;
    logic [N_CH*C_W-1:0] ch_wdata;
    logic [N_CH*C_W-1:0] in_regs;
    logic                glb_we;
    logic                pair_we;
    logic                preset_we;
    logic [PAY_W-1:0]    payload;
    logic [C_W-1:0]      code;
    logic [C_W-1:0]      preset_val;

    octdac_cmd_decode #(.N_CH(N_CH), .C_W(C_W)) u_dec (
        .word_valid (word_valid),
        .word_data  (word_data),
        .twos_fmt   (twos_fmt),
        .ch_we      (ch_we),
        .ch_wdata   (ch_wdata),
        .glb_we     (glb_we),
        .pair_we    (pair_we),
        .preset_we  (preset_we),
        .payload    (payload),
        .code       (code)
    );

    octdac_ctrl_regs #(.N_PAIR(N_PAIR), .C_W(C_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_we     (glb_we),
        .pair_we    (pair_we),
        .preset_we  (preset_we),
        .payload    (payload),
        .code       (code),
        .chip_pdn   (chip_pdn),
        .cascade_en (cascade_en),
        .twos_fmt   (twos_fmt),
        .pair_pdn   (pair_pdn),
        .pair_fast  (pair_fast),
        .preset_val (preset_val)
    );

    octdac_channel_bank #(.N_CH(N_CH), .C_W(C_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_we      (ch_we),
        .ch_wdata   (ch_wdata),
        .load_n     (load_n),
        .preset_n   (preset_n),
        .preset_val (preset_val),
        .in_regs    (in_regs),
        .ch_code    (ch_code)
    );
endmodule

// File: rtl/octdac_checker.sv
// Module: temporal checks on the register file, bound to the top module.
// Assumes the default eight-channel, 8-bit configuration.
module octdac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic [15:0] word_data,
    input logic        load_n,
    input logic        preset_n,
    input logic [63:0] ch_code,
    input logic [63:0] in_regs,
    input logic [3:0]  pair_pdn,
    input logic [3:0]  pair_fast,
    input logic        chip_pdn,
    input logic        cascade_en,
    input logic        twos_fmt
);
    logic [3:0] adr;
    logic [1:0] pk;
    always_comb begin
        adr = word_data[15:12];
        pk  = adr[1:0];
    end

    AST_LOAD_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(preset_n) && $past(load_n) && $past(rst_n)) |-> $stable(ch_code)); // R7

    AST_PRESET_RELEASE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(!preset_n) && $past(rst_n)) |-> (ch_code == $past(ch_code))); // R10

    AST_RESERVED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && adr == 4'd11) |=> $stable({chip_pdn, cascade_en, twos_fmt, pair_pdn, pair_fast, in_regs})); // R5

    AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && adr >= 4'd12) |=> (in_regs[16*$past(pk) +: 8] == ~in_regs[16*$past(pk)+8 +: 8])); // R6

    AST_GLB_PDN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && adr == 4'd8) |=> (chip_pdn == $past(word_data[4]))); // R3
endmodule

bind octal_dac_regfile octdac_checker u_octdac_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .load_n     (load_n),
    .preset_n   (preset_n),
    .ch_code    (ch_code),
    .in_regs    (in_regs),
    .pair_pdn   (pair_pdn),
    .pair_fast  (pair_fast),
    .chip_pdn   (chip_pdn),
    .cascade_en (cascade_en),
    .twos_fmt   (twos_fmt)
);

// File: tb/test_octal_dac_regfile.sv
module test_octal_dac_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid;
    logic [15:0] word_data;
    logic        load_n;
    logic        preset_n;
    logic [63:0] ch_code;
    logic [3:0]  pair_pdn;
    logic [3:0]  pair_fast;
    logic        chip_pdn;
    logic        cascade_en;
    logic        twos_fmt;

    int checks = 0;
    int failures = 0;

    // Reference model state
    logic [7:0] m_in [8];
    logic [7:0] m_lat [8];
    logic [7:0] m_pv;
    logic       m_pd, m_cas, m_tw;
    logic [3:0] m_ppd, m_pf;

    always #(CLK_PERIOD/2) clk = ~clk;

    octal_dac_regfile i_octal_dac_regfile (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .load_n(load_n), .preset_n(preset_n), .ch_code(ch_code),
        .pair_pdn(pair_pdn), .pair_fast(pair_fast), .chip_pdn(chip_pdn),
        .cascade_en(cascade_en), .twos_fmt(twos_fmt)
    );

    function automatic logic [7:0] conv(input logic [7:0] raw, input logic tw);
        return tw ? (raw ^ 8'h80) : raw;
    endfunction

    // Advance the model by one clock edge using the applied inputs.
    task automatic model_edge();
        logic [7:0] c;
        int a;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_in[i] = 8'h00; m_lat[i] = 8'h00; end
            m_pv = 8'h00; m_pd = 1'b0; m_cas = 1'b0; m_tw = 1'b0; m_ppd = 4'h0; m_pf = 4'h0;
            return;
        end
        for (int i = 0; i < 8; i++) begin
            if (!preset_n)   m_lat[i] = m_pv;
            else if (!load_n) m_lat[i] = m_in[i];
        end
        if (word_valid) begin
            a = int'(word_data[15:12]);
            c = conv(word_data[11:4], m_tw);
            if (a < 8) m_in[a] = c;
            else if (a == 8) begin
                m_pd = word_data[4]; m_cas = word_data[3]; m_tw = word_data[0];
            end else if (a == 9) begin
                m_ppd = word_data[7:4]; m_pf = word_data[3:0];
            end else if (a == 10) m_pv = c;
            else if (a >= 12) begin
                m_in[2*(a-12)]   = c;
                m_in[2*(a-12)+1] = ~c;
            end
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        logic [63:0] e;
        for (int i = 0; i < 8; i++) e[i*8 +: 8] = preset_n ? m_lat[i] : m_pv;
        check(tag, ch_code, e);
        check(tag, {51'd0, chip_pdn, cascade_en, twos_fmt, pair_pdn, pair_fast},
                   {51'd0, m_pd, m_cas, m_tw, m_ppd, m_pf});
    endtask

    // Apply one cycle of inputs, update the model at the edge, compare at negedge.
    task automatic step(input logic v, input logic [15:0] d, input logic ld,
                        input logic pr, input string tag);
        word_valid = v; word_data = d; load_n = ld; preset_n = pr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_model(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        rst_n = 1'b0; word_valid = 1'b0; word_data = '0; load_n = 1'b1; preset_n = 1'b1;
        @(negedge clk);
        step(1'b0, 16'h0, 1'b1, 1'b1, "R11");
        step(1'b1, 16'h1230, 1'b0, 1'b1, "R11");
        check("R11 reset zero", {ch_code, 6'd0, chip_pdn, cascade_en, twos_fmt, pair_pdn, pair_fast}, '0);
        rst_n = 1'b1;

        // R7: load high holds outputs; R1 low bits ignored
        step(1'b1, {4'd0, 8'h5A, 4'hF}, 1'b1, 1'b1, "R7");
        step(1'b0, 16'h0, 1'b1, 1'b1, "R7");
        check("R7 load high holds", ch_code, 64'h0);
        step(1'b0, 16'h0, 1'b0, 1'b1, "R7");
        check("R1 R2 channel A code", {56'd0, ch_code[7:0]}, 64'h5A);

        // R2: last channel
        step(1'b1, {4'd7, 8'hC3, 4'h0}, 1'b0, 1'b1, "R2");
        step(1'b0, 16'h0, 1'b0, 1'b1, "R2");
        check("R2 channel H code", {56'd0, ch_code[63:56]}, 64'hC3);

        // R6: pair write of full scale
        step(1'b1, {4'd12, 8'hFF, 4'h0}, 1'b0, 1'b1, "R6");
        step(1'b0, 16'h0, 1'b0, 1'b1, "R6");
        check("R6 pair AB", {48'd0, ch_code[15:0]}, 64'h00FF);

        // R3: global control
        step(1'b1, {4'd8, 12'h019}, 1'b0, 1'b1, "R3");
        check("R3 global fields", {61'd0, chip_pdn, cascade_en, twos_fmt}, 64'h7);

        // R9: two's-complement pair write on CD
        step(1'b1, {4'd13, 8'h00, 4'h0}, 1'b0, 1'b1, "R9");
        step(1'b0, 16'h0, 1'b0, 1'b1, "R9");
        check("R9 offset then complement", {48'd0, ch_code[31:16]}, 64'h7F80);

        // R4: pair controls
        step(1'b1, {4'd9, 12'h0A5}, 1'b0, 1'b1, "R4");
        check("R4 pair fields", {56'd0, pair_pdn, pair_fast}, 64'hA5);

        // R5: reserved address
        step(1'b1, {4'd11, 12'hFFF}, 1'b0, 1'b1, "R5");
        step(1'b0, 16'h0, 1'b0, 1'b1, "R5");
        check("R5 reserved ignored", {ch_code[31:0], 21'd0, chip_pdn, cascade_en, twos_fmt, pair_pdn, pair_fast},
              {32'h7F8000FF, 21'd0, 3'b111, 8'hA5});

        // R8: preset never written gives zero immediately
        word_valid = 1'b0; load_n = 1'b1; preset_n = 1'b0;
        #1;
        check("R8 preset unwritten", ch_code, 64'h0);
        step(1'b0, 16'h0, 1'b1, 1'b0, "R8");
        step(1'b1, {4'd10, 8'h40, 4'h0}, 1'b1, 1'b0, "R8");
        check("R8 R9 preset forced", ch_code, {8{8'hC0}});
        step(1'b0, 16'h0, 1'b0, 1'b0, "R10");
        // R10: release with load high keeps preset value
        step(1'b0, 16'h0, 1'b1, 1'b1, "R10");
        check("R10 release keeps", ch_code, {8{8'hC0}});
        step(1'b0, 16'h0, 1'b1, 1'b1, "R10");
        step(1'b0, 16'h0, 1'b0, 1'b1, "R10");
        check("R10 next load restores", ch_code, 64'hC3000000_7F8000FF);

        step(1'b1, {4'd8, 12'h000}, 1'b0, 1'b1, "R3");

        // Random mix checked against the model (R1 decode under all addresses)
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 2) == 0, 16'($urandom), ($urandom % 10) < 3,
                 ($urandom % 10) != 0, "R1 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule